// File: doc/BRIEF.md
# Low-Power Lane Request Receiver

This block sits on the receive side of a serial data lane and watches the two single-ended low-power line bits, sampled on the system clock. It starts from the stop condition, where both lines are high. From there it tells apart the three line-state sequences a transmitter uses to ask for something: a high-speed burst, a change of lane direction, or entry into escape mode. The escape and turnaround sequences begin the same way, so the block keeps track of the shared prefix and only decides when the sequences diverge.

Once escape mode is entered, the same state machine decodes spaced-one-hot symbols. Every bit is a mark followed by a space. The first eight bits form an entry command. One command value starts low-power data transfer, and each following byte is then presented with a one-cycle strobe. Another command value puts the lane into the ultra-low-power state. The block then waits for a sufficiently long wakeup mark followed by the stop state. Every line state must stay stable for a programmable number of clocks before it is accepted.

Top module: `lp_lane_req_rx`

## Requirements
- R1: After reset all pulse outputs, `cmdByte`, `rxData` and `ulpsActive` are zero.
- R2: A line state held for fewer than `STABLE_CYCLES` clocks is discarded. A state held for `STABLE_CYCLES`+2 clocks or more is accepted. Two accepted changes are never on adjacent cycles.
- R3: From stop (`lpLines`=2'b11), the accepted states 2'b01 then 2'b00 produce one `hsReq` pulse. At most one of the request pulses and `errPulse` is high in any cycle.
- R4: From stop, the states 2'b10, 2'b00, 2'b01, 2'b00 produce one `escReq` pulse, and escape decoding begins.
- R5: From stop, the states 2'b10, 2'b00, 2'b10, 2'b00 produce one `taReq` pulse.
- R6: A state that breaks a request sequence (other than a return to 2'b11) gives one `errPulse`. After that, no request is recognised until 2'b11 has been seen again.
- R7: In escape mode, a mark of 2'b01 followed by the space 2'b00 is a 0 bit, and a mark of 2'b10 followed by 2'b00 is a 1 bit. Bits arrive least significant first. The first 8 bits are presented on `cmdByte` with a one-cycle `cmdValid`.
- R8: Two marks with no space between them give `errPulse`. The block then waits for stop, and no command completes from the rest of the stream.
- R9: After command 8'hE1, every further group of 8 bits is presented on `rxData` with a one-cycle `rxValid`.
- R10: In escape mode, after a space, the states 2'b10 then 2'b11 end escape mode. A new request is then recognised.
- R11: Command 8'h1E raises `ulpsActive` in the same cycle as its `cmdValid`.
- R12: In the ultra-low-power state, a 2'b10 mark held for at least `WAKE_CYCLES` clocks, then 2'b11, clears `ulpsActive`. A shorter mark followed by 2'b11 gives `errPulse` and leaves `ulpsActive` set.
- R13: After any command other than 8'hE1 or 8'h1E, further bits produce no `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| lpLines | input | 2 | Low-power line bits; bit 1 is the positive line, bit 0 the negative line |
| escReq | output | 1 | One-cycle pulse on a recognised escape request |
| hsReq | output | 1 | One-cycle pulse on a recognised high-speed request |
| taReq | output | 1 | One-cycle pulse on a recognised turnaround request |
| cmdValid | output | 1 | One-cycle strobe when the entry command completes |
| cmdByte | output | 8 | Last decoded entry command |
| rxValid | output | 1 | One-cycle strobe for a received low-power data byte |
| rxData | output | 8 | Last received data byte |
| ulpsActive | output | 1 | High while the lane is in the ultra-low-power state |
| errPulse | output | 1 | One-cycle pulse on a protocol violation |

## Verification
The hardest case to reach is the wakeup window. The lane must first be driven through escape entry and a full 8-bit ultra-low-power command. Only then can a mark of a chosen length be applied against the wakeup counter. The bench drives a complete escape entry and the 8'h1E command. It then applies a mark of half the wakeup length, which must be refused, and afterwards one that is longer than the wakeup length, which must be accepted. A second hard case is the mark-after-mark violation in the middle of a command byte, which needs escape entry first. Random command bytes and payloads cover the decoding of the bit order.

// File: rtl/lprx_pkg.sv
package lprx_pkg;

  localparam logic [1:0] LP00 = 2'b00;
  localparam logic [1:0] LP01 = 2'b01;
  localparam logic [1:0] LP10 = 2'b10;
  localparam logic [1:0] LP11 = 2'b11;

  localparam logic [7:0] CMD_ULPS = 8'h1E;
  localparam logic [7:0] CMD_LPDT = 8'hE1;

  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic clearBits;
    logic latchCmd;
    logic latchData;
    logic wakeRun;
  } dpStrobe_t;

endpackage

// File: rtl/lprx_filter.sv
module lprx_filter #(
  parameter int STABLE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lpLines,
  output logic [1:0] lineState,
  output logic       lineEvt
);
  localparam int CW = (STABLE_CYCLES > 2) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(STABLE_CYCLES - 1);

  logic [1:0]    rawQ;
  logic [1:0]    candQ;
  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ      <= 2'b00;
      candQ     <= 2'b00;
      holdCnt   <= '0;
      lineState <= 2'b00;
      lineEvt   <= 1'b0;
    end else begin
      rawQ <= lpLines;
      if (rawQ != candQ) begin
        candQ   <= rawQ;
        holdCnt <= '0;
      end else if (holdCnt != CNT_MAX) begin
        holdCnt <= holdCnt + 1'b1;
      end
      if (rawQ == candQ && holdCnt == CNT_MAX && candQ != lineState) begin
        lineState <= candQ;
        lineEvt   <= 1'b1;
      end else begin
        lineEvt <= 1'b0;
      end
    end
  end

  // R2: accepted changes are spaced by the stability window
  p_evt_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    lineEvt |=> !lineEvt);

endmodule

// File: rtl/lprx_datapath.sv
module lprx_datapath
  import lprx_pkg::*;
#(
  parameter int WAKE_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  output logic [7:0] nextByte,
  output logic       lastBit,
  output logic       wakeDone,
  output logic [7:0] cmdByte,
  output logic       cmdValid,
  output logic [7:0] rxData,
  output logic       rxValid
);
  localparam int WCW = $clog2(WAKE_CYCLES + 1);
  localparam logic [WCW-1:0] WAKE_LIM = WCW'(WAKE_CYCLES);

  logic [7:0]     shReg;
  logic [2:0]     bitCnt;
  logic [WCW-1:0] wakeCnt;

  assign nextByte = {strobe.bitVal, shReg[7:1]};
  assign lastBit  = (bitCnt == 3'd7);
  assign wakeDone = (wakeCnt >= WAKE_LIM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      wakeCnt  <= '0;
      cmdByte  <= '0;
      cmdValid <= 1'b0;
      rxData   <= '0;
      rxValid  <= 1'b0;
    end else begin
      if (strobe.clearBits) begin
        shReg  <= '0;
        bitCnt <= '0;
      end else if (strobe.shiftEn) begin
        shReg  <= nextByte;
        bitCnt <= bitCnt + 3'd1;
      end
      if (!strobe.wakeRun)  wakeCnt <= '0;
      else if (!wakeDone)   wakeCnt <= wakeCnt + 1'b1;
      cmdValid <= strobe.latchCmd;
      if (strobe.latchCmd) cmdByte <= nextByte;
      rxValid <= strobe.latchData;
      if (strobe.latchData) rxData <= nextByte;
    end
  end

  // R9: data bytes only follow the data-transfer command
  p_rx_lpdt_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> cmdByte == CMD_LPDT);

endmodule

// File: rtl/lprx_ctrl.sv
module lprx_ctrl
  import lprx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lineState,
  input  logic       lineEvt,
  input  logic [7:0] nextByte,
  input  logic       lastBit,
  input  logic       wakeDone,
  output dpStrobe_t  strobe,
  output logic       escReq,
  output logic       hsReq,
  output logic       taReq,
  output logic       errPulse,
  output logic       ulpsActive
);
  typedef enum logic [3:0] {
    S_WAIT, S_STOP, S_E1, S_E2, S_E3, S_T3, S_H1,
    S_SPACE, S_MARK, S_ULPS, S_WAKE
  } state_t;
  typedef enum logic [1:0] {PH_CMD, PH_LPDT, PH_OTHER} phase_t;

  state_t st, nxt;
  phase_t phase, nxtPhase;
  logic   markBit, nxtMark;
  logic   esc, hs, ta, err, ulpsSet, ulpsClr;

  always_comb begin
    nxt      = st;
    nxtPhase = phase;
    nxtMark  = markBit;
    {esc, hs, ta, err, ulpsSet, ulpsClr} = '0;
    strobe         = '0;
    strobe.bitVal  = markBit;
    strobe.wakeRun = (st == S_WAKE);
    if (lineEvt) begin
      unique case (st)
        S_WAIT: if (lineState == LP11) nxt = S_STOP;
        S_STOP: begin
          if (lineState == LP10)      nxt = S_E1;
          else if (lineState == LP01) nxt = S_H1;
          else begin err = 1'b1; nxt = S_WAIT; end
        end
        S_E1, S_E2, S_E3, S_T3, S_H1: begin
          if (st == S_E1 && lineState == LP00)      nxt = S_E2;
          else if (st == S_E2 && lineState == LP01) nxt = S_E3;
          else if (st == S_E2 && lineState == LP10) nxt = S_T3;
          else if (st == S_E3 && lineState == LP00) begin
            esc = 1'b1; nxt = S_SPACE; nxtPhase = PH_CMD; strobe.clearBits = 1'b1;
          end else if (st == S_T3 && lineState == LP00) begin
            ta = 1'b1; nxt = S_WAIT;
          end else if (st == S_H1 && lineState == LP00) begin
            hs = 1'b1; nxt = S_WAIT;
          end else if (lineState == LP11) nxt = S_STOP;
          else begin err = 1'b1; nxt = S_WAIT; end
        end
        S_SPACE: begin
          if (lineState == LP01)      begin nxtMark = 1'b0; nxt = S_MARK; end
          else if (lineState == LP10) begin nxtMark = 1'b1; nxt = S_MARK; end
          else begin err = 1'b1; nxt = S_WAIT; end
        end
        S_MARK: begin
          if (lineState == LP00) begin
            strobe.shiftEn = 1'b1;
            nxt = S_SPACE;
            if (lastBit && phase == PH_CMD) begin
              strobe.latchCmd = 1'b1;
              if (nextByte == CMD_ULPS) begin
                ulpsSet = 1'b1; nxt = S_ULPS;
              end else if (nextByte == CMD_LPDT) nxtPhase = PH_LPDT;
              else nxtPhase = PH_OTHER;
            end else if (lastBit && phase == PH_LPDT) begin
              strobe.latchData = 1'b1;
            end
          end else if (lineState == LP11 && markBit) nxt = S_STOP;
          else begin err = 1'b1; nxt = S_WAIT; end
        end
        S_ULPS: if (lineState == LP10) nxt = S_WAKE;
        S_WAKE: begin
          if (lineState == LP11) begin
            if (wakeDone) begin ulpsClr = 1'b1; nxt = S_STOP; end
            else begin err = 1'b1; nxt = S_ULPS; end
          end else nxt = S_ULPS;
        end
        default: nxt = S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= S_WAIT;
      phase      <= PH_CMD;
      markBit    <= 1'b0;
      escReq     <= 1'b0;
      hsReq      <= 1'b0;
      taReq      <= 1'b0;
      errPulse   <= 1'b0;
      ulpsActive <= 1'b0;
    end else begin
      st       <= nxt;
      phase    <= nxtPhase;
      markBit  <= nxtMark;
      escReq   <= esc;
      hsReq    <= hs;
      taReq    <= ta;
      errPulse <= err;
      if (ulpsSet)      ulpsActive <= 1'b1;
      else if (ulpsClr) ulpsActive <= 1'b0;
    end
  end

  // R3: requests and errors never coincide
  p_one_event_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({escReq, hsReq, taReq, errPulse}));

  // R12: leaving ultra-low-power only with the lines at stop
  p_ulps_exit_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ulpsActive) |-> lineState == LP11);

endmodule

// File: rtl/lp_lane_req_rx.sv
module lp_lane_req_rx
  import lprx_pkg::*;
#(
  parameter int STABLE_CYCLES = 3,
  parameter int WAKE_CYCLES   = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lpLines,
  output logic       escReq,
  output logic       hsReq,
  output logic       taReq,
  output logic       cmdValid,
  output logic [7:0] cmdByte,
  output logic       rxValid,
  output logic [7:0] rxData,
  output logic       ulpsActive,
  output logic       errPulse
);
  logic [1:0] lineState;
  logic       lineEvt;
  logic [7:0] nextByte;
  logic       lastBit;
  logic       wakeDone;
  dpStrobe_t  strobe;

  lprx_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filter (
    .clk(clk), .rstN(rstN), .lpLines(lpLines),
    .lineState(lineState), .lineEvt(lineEvt));

  lprx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lineState(lineState), .lineEvt(lineEvt),
    .nextByte(nextByte), .lastBit(lastBit), .wakeDone(wakeDone),
    .strobe(strobe), .escReq(escReq), .hsReq(hsReq), .taReq(taReq),
    .errPulse(errPulse), .ulpsActive(ulpsActive));

  lprx_datapath #(.WAKE_CYCLES(WAKE_CYCLES)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nextByte(nextByte),
    .lastBit(lastBit), .wakeDone(wakeDone), .cmdByte(cmdByte),
    .cmdValid(cmdValid), .rxData(rxData), .rxValid(rxValid));

  // R11: entering ultra-low-power coincides with its command strobe
  p_ulps_cmd_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ulpsActive) |-> cmdValid && cmdByte == CMD_ULPS);

endmodule

// File: tb/lp_lane_req_rx_bench.sv
module lp_lane_req_rx_bench;
  localparam int STABLE = 3;
  localparam int WAKE   = 40;
  localparam int HOLD   = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] lpLines = 2'b11;
  logic escReq, hsReq, taReq, cmdValid, rxValid, ulpsActive, errPulse;
  logic [7:0] cmdByte, rxData;

  lp_lane_req_rx #(.STABLE_CYCLES(STABLE), .WAKE_CYCLES(WAKE)) u_lp_lane_req_rx (
    .clk(clk), .rstN(rstN), .lpLines(lpLines), .escReq(escReq), .hsReq(hsReq),
    .taReq(taReq), .cmdValid(cmdValid), .cmdByte(cmdByte), .rxValid(rxValid),
    .rxData(rxData), .ulpsActive(ulpsActive), .errPulse(errPulse));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int escCnt, hsCnt, taCnt, errCnt, cmdCnt, rxCnt;
  logic [7:0] rxLog [0:15];

  always @(negedge clk) begin
    if (rstN) begin
      if (escReq)   escCnt++;
      if (hsReq)    hsCnt++;
      if (taReq)    taCnt++;
      if (errPulse) errCnt++;
      if (cmdValid) cmdCnt++;
      if (rxValid) begin
        if (rxCnt < 16) rxLog[rxCnt] = rxData;
        rxCnt++;
      end
    end
  end

  task automatic clearCounts();
    escCnt = 0; hsCnt = 0; taCnt = 0; errCnt = 0; cmdCnt = 0; rxCnt = 0;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] v, input int n);
    lpLines = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendBit(input bit b);
    drive(b ? 2'b10 : 2'b01, HOLD);
    drive(2'b00, HOLD);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  task automatic escEntry();
    drive(2'b11, HOLD); drive(2'b10, HOLD); drive(2'b00, HOLD);
    drive(2'b01, HOLD); drive(2'b00, HOLD);
  endtask

  task automatic escExit();
    drive(2'b10, HOLD); drive(2'b11, HOLD);
  endtask

  function automatic int expRxCount(input logic [7:0] cmd, input int n);
    return (cmd == 8'hE1) ? n : 0;
  endfunction

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    clearCounts();
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check({escReq, hsReq, taReq, cmdValid, rxValid, ulpsActive, errPulse} == 0 &&
          cmdByte == 0 && rxData == 0, "R1", int'(cmdByte), 0);
    drive(2'b11, HOLD);

    // R2 one-cycle glitch ignored, then high-speed request
    clearCounts();
    drive(2'b00, 1); drive(2'b11, HOLD);
    drive(2'b01, HOLD); drive(2'b00, HOLD);
    check(errCnt == 0, "R2", errCnt, 0);
    // R3 high-speed request
    check(hsCnt == 1, "R3", hsCnt, 1);

    // R4 escape entry
    clearCounts();
    escEntry();
    check(escCnt == 1, "R4", escCnt, 1);
    escExit();

    // R5 turnaround
    clearCounts();
    drive(2'b10, HOLD); drive(2'b00, HOLD); drive(2'b10, HOLD); drive(2'b00, HOLD);
    check(taCnt == 1 && escCnt == 0, "R5", taCnt, 1);
    drive(2'b11, HOLD);

    // R6 broken sequence, then no request until stop
    clearCounts();
    drive(2'b10, HOLD); drive(2'b01, HOLD);
    check(errCnt == 1, "R6", errCnt, 1);
    drive(2'b00, HOLD); drive(2'b01, HOLD); drive(2'b00, HOLD);
    check(escCnt == 0 && hsCnt == 0, "R6", escCnt + hsCnt, 0);

    // R7 command decode, R13 other command ignores data
    clearCounts();
    escEntry();
    sendByte(8'hA5);
    check(cmdCnt == 1 && cmdByte == 8'hA5, "R7", int'(cmdByte), 8'hA5);
    sendByte(8'h3C);
    check(rxCnt == 0, "R13", rxCnt, 0);
    // R10 exit then new request
    escExit();
    drive(2'b01, HOLD); drive(2'b00, HOLD);
    check(hsCnt == 1 && errCnt == 0, "R10", hsCnt, 1);
    drive(2'b11, HOLD);

    // R9 data transfer
    clearCounts();
    escEntry();
    sendByte(8'hE1); sendByte(8'h3C); sendByte(8'h81);
    check(rxCnt == 2, "R9", rxCnt, 2);
    check(rxLog[0] == 8'h3C && rxLog[1] == 8'h81, "R9", int'(rxLog[1]), 8'h81);
    escExit();

    // R8 mark after mark
    clearCounts();
    escEntry();
    sendBit(1'b1); sendBit(1'b0);
    drive(2'b01, HOLD); drive(2'b10, HOLD);
    check(errCnt == 1, "R8", errCnt, 1);
    drive(2'b00, HOLD);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    check(cmdCnt == 0, "R8", cmdCnt, 0);
    drive(2'b11, HOLD);

    // R11 ultra-low-power entry
    clearCounts();
    escEntry();
    sendByte(8'h1E);
    check(ulpsActive == 1'b1 && cmdByte == 8'h1E, "R11", int'(ulpsActive), 1);
    drive(2'b00, 3 * HOLD);
    // R12 short wakeup refused
    drive(2'b10, WAKE / 2); drive(2'b11, HOLD);
    check(errCnt == 1 && ulpsActive == 1'b1, "R12", errCnt, 1);
    drive(2'b00, HOLD);
    drive(2'b10, WAKE + 20); drive(2'b11, HOLD);
    check(ulpsActive == 1'b0 && errCnt == 1, "R12", int'(ulpsActive), 0);

    // random commands and payloads
    for (int it = 0; it < 8; it++) begin
      logic [7:0] cmd;
      int n;
      cmd = 8'($urandom);
      if (it % 2 == 0) cmd = 8'hE1;
      if (cmd == 8'h1E) cmd = 8'h5A;
      n = int'($urandom % 4);
      clearCounts();
      escEntry();
      sendByte(cmd);
      check(cmdCnt == 1 && cmdByte == cmd, "R7", int'(cmdByte), int'(cmd));
      begin
        logic [7:0] pay [0:3];
        for (int k = 0; k < n; k++) begin
          pay[k] = 8'($urandom);
          sendByte(pay[k]);
        end
        check(rxCnt == expRxCount(cmd, n), "R9", rxCnt, expRxCount(cmd, n));
        if (cmd == 8'hE1)
          for (int k = 0; k < n; k++)
            check(rxLog[k] == pay[k], "R9", int'(rxLog[k]), int'(pay[k]));
      end
      escExit();
      check(errCnt == 0, "R10", errCnt, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule